// File: doc/BRIEF.md
# Gated LFSR Signature Analyzer

This block folds a serial probe stream into a 16-bit signature, the way a board-test signature analyzer does. Three framing probes (a sampling clock, a window-open signal and a window-close signal) and one data probe arrive as plain asynchronous levels. They are brought into the system clock domain, and their active edges are found by comparing each synchronized level with its registered previous value. On every qualifying edge of the probe clock inside an open window, the probe data bit is pushed into a 16-bit feedback shift register.

When the window closes cleanly, the register contents are latched, a one-cycle valid pulse is given, and the latched value is also shown as four ASCII characters from a 16-symbol alphabet. Framing that makes no sense gives a one-cycle error pulse and no new signature. If a clean window gives a different result from the clean window before it, the unstable flag is raised. This points to a noisy node or a race between data and clock. Each framing probe has its own polarity select, so the window can be set to match whatever edges a given test setup calls for.

Top module: `gated_signature_analyzer`

## Requirements
- R1: The register holds 16 bits numbered 1 to 16, with bit k on `signature[k-1]`. On each accepted shift, bits move up by one and bit 1 takes probe data XOR bit 7 XOR bit 9 XOR bit 12 XOR bit 16. A shift happens only at an active probe-clock edge while the window is open.
- R2: Open and close edges are held until the next active probe-clock edge and take effect there. The opening edge clears the register, and the data sampled at that same clock edge is the first bit shifted in. The data at the closing clock edge is not shifted in.
- R3: A data probe held low for a whole window gives the signature 0x0000.
- R4: Each framing probe has its own polarity select: `pol_*` at 1 means the rising edge is active, and 0 means the falling edge is active. The usual setting is open on a rising edge, close on a falling edge and sample on a falling edge. Inverting all three selects together with all three waveforms gives the same signature.
- R5: `sig_chars` holds four 8-bit ASCII codes, with the most significant nibble in bits 31:24. Nibble values 0 to 9 show as '0' to '9', and values 10 to 15 show as 'A', 'C', 'F', 'H', 'P' and 'U' in that order.
- R6: A close edge on an open window latches the signature and pulses `sig_valid` for one cycle. `signature` keeps its value until the next clean close.
- R7: `frame_err` pulses for one cycle, and neither the signature nor `sig_valid` changes, in three cases: a close with no open window; an open while a window is open (that window is dropped); and open and close taken at the same clock edge.
- R8: On each clean close, `unstable` becomes 1 if the new signature differs from the previous clean one, and 0 otherwise. It is 0 after the first clean window following reset, and it holds its value between clean closes.
- R9: Synchronous active-high reset clears the signature (characters "0000"), `sig_valid`, `frame_err` and `unstable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_clk | input | 1 | Asynchronous sampling-clock probe |
| probe_start | input | 1 | Asynchronous window-open probe |
| probe_stop | input | 1 | Asynchronous window-close probe |
| probe_data | input | 1 | Asynchronous data probe |
| pol_clk | input | 1 | Active edge of probe_clk: 1 rising, 0 falling |
| pol_start | input | 1 | Active edge of probe_start: 1 rising, 0 falling |
| pol_stop | input | 1 | Active edge of probe_stop: 1 rising, 0 falling |
| signature | output | 16 | Latched signature of the last clean window |
| sig_chars | output | 32 | Four ASCII display codes, most significant nibble first |
| sig_valid | output | 1 | One-cycle pulse on a clean close |
| frame_err | output | 1 | One-cycle pulse on invalid framing |
| unstable | output | 1 | Last two clean signatures differ |

## Verification
The feedback is exercised with several data streams: all zeros, all ones, alternating bits, a single one bit, and two irregular words of different lengths. All zeros confirms the null signature. The single-bit window pins down where the first sample goes and whether the closing sample is left out. The long irregular words bring every tap into play, and all of these are compared against a bench model built from the tap equation. A repeated stream and a changed stream tell the unstable flag's two outcomes apart. An inverted-polarity run, fed the same data as an earlier run, separates real edge selection from fixed edges. Three bad framings (a close alone, a second open, and open with close at the same clock edge) show that faults never disturb the held signature.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int SIG_W   = 16;
    localparam int NIB_W   = 4;
    localparam int NIB_N   = SIG_W / NIB_W;
    localparam int CHAR_W  = 8;
    localparam int FRAME_N = 3;           // clock, open, close probes

    // feedback taps at bit numbers 7, 9, 12 and 16 (vector index = number - 1)
    localparam logic [SIG_W-1:0] TAP_MASK = (SIG_W'(1) << 6) | (SIG_W'(1) << 8)
                                          | (SIG_W'(1) << 11) | (SIG_W'(1) << 15);

    typedef logic [SIG_W-1:0] sig_t;

    // indices of the framing probes inside the front-end vectors
    localparam int IDX_CLK   = 0;
    localparam int IDX_START = 1;
    localparam int IDX_STOP  = 2;

    typedef struct packed {
        logic clk_evt;
        logic start_evt;
        logic stop_evt;
        logic data;
    } probe_evt_t;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_OPEN,
        ACT_SHIFT,
        ACT_CLOSE,
        ACT_FAULT
    } win_act_t;

    function automatic sig_t lfsr_step(input sig_t cur, input logic din);
        logic fb;
        fb = din ^ (^(cur & TAP_MASK));
        return {cur[SIG_W-2:0], fb};
    endfunction

    function automatic logic [CHAR_W-1:0] nib_char(input logic [NIB_W-1:0] n);
        logic [CHAR_W-1:0] c;
        case (n)
            4'hA:    c = 8'h41;                       // 'A'
            4'hB:    c = 8'h43;                       // 'C'
            4'hC:    c = 8'h46;                       // 'F'
            4'hD:    c = 8'h48;                       // 'H'
            4'hE:    c = 8'h50;                       // 'P'
            4'hF:    c = 8'h55;                       // 'U'
            default: c = 8'h30 + {4'h0, n};           // '0'..'9'
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sa_probe_front.sv
module sa_probe_front
    import sa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       probe_clk,
    input  logic       probe_start,
    input  logic       probe_stop,
    input  logic       probe_data,
    input  logic       pol_clk,
    input  logic       pol_start,
    input  logic       pol_stop,
    output probe_evt_t evt
);

    localparam int RAW_N = FRAME_N + 1;
    localparam int IDX_DATA = FRAME_N;

    logic [RAW_N-1:0]   raw;
    logic [RAW_N-1:0]   lvl;
    logic [FRAME_N-1:0] pol;
    logic [FRAME_N-1:0] prev_q;
    logic [FRAME_N-1:0] hit;

    assign raw[IDX_CLK]   = probe_clk;
    assign raw[IDX_START] = probe_start;
    assign raw[IDX_STOP]  = probe_stop;
    assign raw[IDX_DATA]  = probe_data;

    assign pol[IDX_CLK]   = pol_clk;
    assign pol[IDX_START] = pol_start;
    assign pol[IDX_STOP]  = pol_stop;

    // one synchronizer chain per probe
    for (genvar g = 0; g < RAW_N; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl[FRAME_N-1:0];
    end

    // edge finder, polarity picked per probe
    for (genvar g = 0; g < FRAME_N; g++) begin : g_edge
        logic rise, fall;
        assign rise  = lvl[g] & ~prev_q[g];
        assign fall  = ~lvl[g] & prev_q[g];
        assign hit[g] = pol[g] ? rise : fall;
    end

    assign evt.clk_evt   = hit[IDX_CLK];
    assign evt.start_evt = hit[IDX_START];
    assign evt.stop_evt  = hit[IDX_STOP];
    assign evt.data      = lvl[IDX_DATA];

endmodule

// File: rtl/sa_lfsr.sv
module sa_lfsr
    import sa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic step,
    input  logic din,
    output sig_t state
);

    sig_t state_q;

    always_ff @(posedge clk) begin
        if (rst)          state_q <= '0;
        else if (restart) state_q <= lfsr_step('0, din);
        else if (step)    state_q <= lfsr_step(state_q, din);
    end

    assign state = state_q;

    // R1: no shift request, no movement in the register
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(restart || step) |=> $stable(state_q));

endmodule

// File: rtl/sa_window_ctrl.sv
module sa_window_ctrl
    import sa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  probe_evt_t evt,
    input  sig_t       lfsr_state,
    output logic       lfsr_restart,
    output logic       lfsr_step_en,
    output logic       lfsr_din,
    output sig_t       sig_q,
    output logic       valid_q,
    output logic       err_q,
    output logic       unstable_q
);

    win_state_t win_q;
    logic       start_pend_q, stop_pend_q, have_prev_q;
    logic       start_eff, stop_eff;
    win_act_t   act;

    // framing edges wait for the next active probe-clock edge
    always_ff @(posedge clk) begin
        if (rst) begin
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else if (evt.clk_evt) begin
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else begin
            if (evt.start_evt) start_pend_q <= 1'b1;
            if (evt.stop_evt)  stop_pend_q  <= 1'b1;
        end
    end

    assign start_eff = start_pend_q | evt.start_evt;
    assign stop_eff  = stop_pend_q  | evt.stop_evt;

    always_comb begin
        act = ACT_NONE;
        if (evt.clk_evt) begin
            if (start_eff && stop_eff)  act = ACT_FAULT;
            else if (start_eff)         act = (win_q == WIN_OPEN) ? ACT_FAULT : ACT_OPEN;
            else if (stop_eff)          act = (win_q == WIN_OPEN) ? ACT_CLOSE : ACT_FAULT;
            else if (win_q == WIN_OPEN) act = ACT_SHIFT;
        end
    end

    assign lfsr_restart = (act == ACT_OPEN);
    assign lfsr_step_en = (act == ACT_SHIFT);
    assign lfsr_din     = evt.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q       <= WIN_CLOSED;
            sig_q       <= '0;
            valid_q     <= 1'b0;
            err_q       <= 1'b0;
            unstable_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            case (act)
                ACT_OPEN:  win_q <= WIN_OPEN;
                ACT_CLOSE: begin
                    win_q       <= WIN_CLOSED;
                    sig_q       <= lfsr_state;
                    valid_q     <= 1'b1;
                    unstable_q  <= have_prev_q && (lfsr_state != sig_q);
                    have_prev_q <= 1'b1;
                end
                ACT_FAULT: begin
                    win_q <= WIN_CLOSED;
                    err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7: a framing fault never coincides with a clean close
    p_valid_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && err_q));

    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R6: the held signature moves only together with valid
    p_sig_only_on_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sig_q) |-> valid_q);

    // R7: a fault leaves the held signature alone
    p_err_keeps_sig_r7: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(sig_q));

    // R8: the unstable flag is updated only on a clean close
    p_unstable_on_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(unstable_q) |-> valid_q);

endmodule

// File: rtl/sa_display.sv
module sa_display
    import sa_pkg::*;
(
    input  sig_t                      sig,
    output logic [NIB_N*CHAR_W-1:0]   chars
);

    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        assign chars[g*CHAR_W +: CHAR_W] = nib_char(sig[g*NIB_W +: NIB_W]);
    end

endmodule

// File: rtl/gated_signature_analyzer.sv
module gated_signature_analyzer
    import sa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        probe_clk,
    input  logic        probe_start,
    input  logic        probe_stop,
    input  logic        probe_data,
    input  logic        pol_clk,
    input  logic        pol_start,
    input  logic        pol_stop,
    output logic [15:0] signature,
    output logic [31:0] sig_chars,
    output logic        sig_valid,
    output logic        frame_err,
    output logic        unstable
);

    probe_evt_t evt;
    sig_t       lfsr_state, held;
    logic       restart, step_en, din;

    sa_probe_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .probe_clk  (probe_clk),
        .probe_start(probe_start),
        .probe_stop (probe_stop),
        .probe_data (probe_data),
        .pol_clk    (pol_clk),
        .pol_start  (pol_start),
        .pol_stop   (pol_stop),
        .evt        (evt)
    );

    sa_lfsr u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .step   (step_en),
        .din    (din),
        .state  (lfsr_state)
    );

    sa_window_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .lfsr_state  (lfsr_state),
        .lfsr_restart(restart),
        .lfsr_step_en(step_en),
        .lfsr_din    (din),
        .sig_q       (held),
        .valid_q     (sig_valid),
        .err_q       (frame_err),
        .unstable_q  (unstable)
    );

    sa_display u_disp (
        .sig  (held),
        .chars(sig_chars)
    );

    assign signature = held;

endmodule

// File: tb/test_gated_signature_analyzer.sv
module test_gated_signature_analyzer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [31:0] VPAT [NVEC] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA,
                                             32'h0000_0001, 32'h1234_5678, 32'hDEAD_BEEF};
    localparam int          VLEN [NVEC] = '{20, 16, 32, 1, 24, 32};

    logic clk = 0, rst = 1;
    logic probe_clk, probe_start, probe_stop, probe_data;
    logic pol_clk, pol_start, pol_stop;
    logic [15:0] signature;
    logic [31:0] sig_chars;
    logic sig_valid, frame_err, unstable;

    int total = 0, bad = 0, n_valid = 0, n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_signature_analyzer i_gated_signature_analyzer (
        .clk(clk), .rst(rst),
        .probe_clk(probe_clk), .probe_start(probe_start),
        .probe_stop(probe_stop), .probe_data(probe_data),
        .pol_clk(pol_clk), .pol_start(pol_start), .pol_stop(pol_stop),
        .signature(signature), .sig_chars(sig_chars),
        .sig_valid(sig_valid), .frame_err(frame_err), .unstable(unstable)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sig_valid) n_valid++;
            if (frame_err) n_err++;
        end
    end

    function automatic logic [15:0] ref_sig(input logic [31:0] pat, input int len);
        logic [15:0] s = '0;
        for (int i = 0; i < len; i++) begin
            logic b = pat[i] ^ s[6] ^ s[8] ^ s[11] ^ s[15];
            s = {s[14:0], b};
        end
        return s;
    endfunction

    function automatic logic [7:0] ref_char(input logic [3:0] n);
        logic [7:0] tbl [6] = '{"A", "C", "F", "H", "P", "U"};
        if (n < 10) return 8'd48 + 8'(n);
        return tbl[n - 10];
    endfunction

    function automatic logic [31:0] ref_chars(input logic [15:0] s);
        return {ref_char(s[15:12]), ref_char(s[11:8]), ref_char(s[7:4]), ref_char(s[3:0])};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pol(input logic pc, input logic ps, input logic pp);
        pol_clk = pc; pol_start = ps; pol_stop = pp;
        probe_clk = ~pc; probe_start = ~ps; probe_stop = ~pp; probe_data = 0;
        wait_cyc(8);
    endtask

    // one probe-clock period; open/close edges placed before the active clock edge
    task automatic probe_step(input logic d, input logic s, input logic p);
        probe_data = d;
        if (s) probe_start = pol_start;
        if (p) probe_stop  = pol_stop;
        wait_cyc(4);
        probe_clk = pol_clk;
        wait_cyc(4);
        probe_clk = ~pol_clk; probe_start = ~pol_start; probe_stop = ~pol_stop;
        wait_cyc(4);
    endtask

    task automatic run_window(input logic [31:0] pat, input int len);
        probe_step(pat[0], 1, 0);
        for (int i = 1; i < len; i++) probe_step(pat[i], 0, 0);
        probe_step(1'b1, 0, 1);   // closing sample must be left out
        wait_cyc(4);
    endtask

    task automatic do_reset;
        rst = 1; wait_cyc(4); rst = 0; wait_cyc(2);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " signature"}, 32'(signature), 32'h0);
        chk({tag, " chars"}, sig_chars, 32'h3030_3030);
        chk({tag, " valid"}, 32'(sig_valid), 32'h0);
        chk({tag, " err"}, 32'(frame_err), 32'h0);
        chk({tag, " unstable"}, 32'(unstable), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_s, prev_s, keep_s;
        int v0, e0;

        set_pol(0, 1, 0);             // default framing (R4)
        do_reset();
        check_reset_state("R9 reset");

        // vector table walk (R1, R2, R3, R5, R6, R8)
        prev_s = '0;
        for (int i = 0; i < NVEC; i++) begin
            v0 = n_valid; e0 = n_err;
            exp_s = ref_sig(VPAT[i], VLEN[i]);
            run_window(VPAT[i], VLEN[i]);
            chk($sformatf("R1 R2 signature vec%0d", i), 32'(signature), 32'(exp_s));
            chk($sformatf("R5 chars vec%0d", i), sig_chars, ref_chars(exp_s));
            chk($sformatf("R6 one valid vec%0d", i), 32'(n_valid - v0), 32'd1);
            chk($sformatf("R7 no err vec%0d", i), 32'(n_err - e0), 32'd0);
            chk($sformatf("R8 unstable vec%0d", i), 32'(unstable),
                32'((i > 0) && (exp_s != prev_s)));
            prev_s = exp_s;
        end
        chk("R3 null signature", 32'(ref_sig(32'h0, 20)), 32'h0);

        // R8: same stream twice -> stable
        run_window(VPAT[5], VLEN[5]);
        chk("R8 repeat stable", 32'(unstable), 32'h0);
        keep_s = signature;

        // R7: close without open
        v0 = n_valid; e0 = n_err;
        probe_step(1'b0, 0, 1); wait_cyc(4);
        chk("R7 stray close err", 32'(n_err - e0), 32'd1);
        chk("R7 stray close sig", 32'(signature), 32'(keep_s));
        chk("R7 stray close no valid", 32'(n_valid - v0), 32'd0);

        // R7: second open inside a window, then close (now stray)
        e0 = n_err;
        probe_step(1'b1, 1, 0); probe_step(1'b0, 0, 0); probe_step(1'b1, 1, 0);
        probe_step(1'b0, 0, 1); wait_cyc(4);
        chk("R7 double open err", 32'(n_err - e0), 32'd2);
        chk("R7 double open sig", 32'(signature), 32'(keep_s));
        chk("R7 double open no valid", 32'(n_valid - v0), 32'd0);

        // R7: open and close at the same clock edge
        e0 = n_err;
        probe_step(1'b1, 1, 1); wait_cyc(4);
        chk("R7 same edge err", 32'(n_err - e0), 32'd1);
        chk("R7 same edge sig", 32'(signature), 32'(keep_s));
        chk("R8 held through faults", 32'(unstable), 32'h0);

        // R4: all polarities inverted, waveforms inverted too
        set_pol(1, 0, 1);
        exp_s = ref_sig(VPAT[4], VLEN[4]);
        run_window(VPAT[4], VLEN[4]);
        chk("R4 inverted polarity signature", 32'(signature), 32'(exp_s));
        chk("R8 changed after faults", 32'(unstable), 32'(exp_s != keep_s));

        // R4: mixed polarity, only the clock flipped back
        set_pol(0, 0, 1);
        exp_s = ref_sig(VPAT[2], VLEN[2]);
        run_window(VPAT[2], VLEN[2]);
        chk("R4 mixed polarity signature", 32'(signature), 32'(exp_s));

        // R9: reset mid-run, then first window is never unstable
        do_reset();
        check_reset_state("R9 second reset");
        set_pol(0, 1, 0);
        exp_s = ref_sig(VPAT[1], VLEN[1]);
        run_window(VPAT[1], VLEN[1]);
        chk("R8 first after reset", 32'(unstable), 32'h0);
        chk("R1 signature after reset", 32'(signature), 32'(exp_s));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule